// File: doc/BRIEF.md
# Static Multi-Queue Pointer Manager

This block keeps track of many logical FIFOs that share one external frame buffer. Each queue owns a fixed, power-of-two region of that buffer. An on-chip table keeps one entry per queue, holding a read pointer, a write pointer and four status bits. An enqueue or dequeue request names a queue. The block then fetches that queue's entry and issues a frame address to the memory-controller port. It advances the pointer that was used, recomputes the status bits and writes the entry back. Every request takes two cycles, and a new request can be accepted on every cycle.

A frame address has two parts. The upper field is the queue number and never changes. The lower field is the frame index, which wraps inside the region. Below both sit zero bits for the byte offset within a frame. Because of this split, the pointer logic is the same for every queue. After reset, a sequencer writes each queue's base pointer into the table and then raises `ready`. Two shared threshold inputs set the almost-empty and almost-full levels.

Top module: `static_queue_ptr_mgr`

## Requirements
- R1: After reset is released, `ready` stays low for exactly NUM_QUEUES clock edges while the table is loaded. It then goes high and stays high. Requests presented while `ready` is low are ignored: they produce no memory access and no status, and they change no pointer.
- R2: An enqueue to a queue that is not full produces `memValid`=1 and `memWrite`=1 two clock edges after the request is sampled. `memAddr` is {queue, tail frame index, six zero bits}, and the tail advances by one frame.
- R3: A dequeue from a queue that is not empty produces `memValid`=1 and `memWrite`=0 two edges after sampling. `memAddr` is formed in the same way from the head frame index, and the head advances by one frame.
- R4: A frame index that advances past DEPTH_FRAMES-1 returns to 0 within the same region. The queue field of the address never changes.
- R5: In the same cycle as the memory output, `statValid` is high, `statQueue` names the queue, and the flags reflect the updated occupancy (tail minus head). `statEmpty` is set when occupancy is 0, and `statFull` when occupancy equals DEPTH_FRAMES.
- R6: `statAlmostEmpty` is set when occupancy ≤ `aeLevel`, and `statAlmostFull` when occupancy ≥ `afLevel`.
- R7: A dequeue from an empty queue makes no memory access and raises no drop. It leaves the pointers unchanged.
- R8: An enqueue to a full queue makes no memory access, pulses `drop` for one cycle and leaves the pointers unchanged.
- R9: Requests to the same queue on consecutive cycles see each other's updates, so back-to-back accesses produce consecutive frame indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqEnq | input | 1 | 1 = enqueue, 0 = dequeue |
| reqQueue | input | 6 | Queue number |
| aeLevel | input | 8 | Almost-empty occupancy threshold |
| afLevel | input | 8 | Almost-full occupancy threshold |
| ready | output | 1 | Table loaded, requests accepted |
| memValid | output | 1 | Memory access strobe |
| memWrite | output | 1 | Access is a frame write |
| memAddr | output | 19 | Byte address of the frame |
| drop | output | 1 | Enqueue refused, queue full |
| statValid | output | 1 | Status for a handled request |
| statQueue | output | 6 | Queue the status belongs to |
| statEmpty | output | 1 | Updated empty flag |
| statFull | output | 1 | Updated full flag |
| statAlmostEmpty | output | 1 | Updated almost-empty flag |
| statAlmostFull | output | 1 | Updated almost-full flag |

## Verification
Every result of a request is due on the second clock edge after the request is sampled: the memory strobe and address, the drop pulse and the status outputs. The bench drives a request on each falling edge. It keeps a two-deep list of expected results and compares the oldest entry two falling edges later, so each check looks at exactly the cycle the pipeline delivers. The `ready` rise is checked at its exact edge count, 64 edges after reset is released. The threshold levels change only during idle gaps, so the flags each request sees are known.

// File: rtl/qm_pkg.sv
package qm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic initWr;   // load one base entry this cycle
    logic live;     // stage-one request is valid
    logic enq;      // stage-one request is an enqueue
  } qmStrobe_t;

  typedef struct packed {
    logic almostFull;
    logic almostEmpty;
    logic full;
    logic empty;
  } qmFlags_t;
endpackage

// File: rtl/qm_ctrl.sv
module qm_ctrl
  import qm_pkg::*;
#(
  parameter int NUM_QUEUES   = 64,
  parameter int DEPTH_FRAMES = 128
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 reqValid,
  input  logic                                 reqEnq,
  input  logic [$clog2(NUM_QUEUES)-1:0]        reqQueue,
  output logic                                 ready,
  output qmStrobe_t                            strobes,
  output logic [$clog2(NUM_QUEUES)-1:0]        s1Queue,
  output logic [$clog2(NUM_QUEUES)+$clog2(DEPTH_FRAMES)-1:0] initBase
);
  localparam int QW = $clog2(NUM_QUEUES);
  localparam int DW = $clog2(DEPTH_FRAMES);
  localparam int BW = QW + DW;

  typedef enum logic {ST_LOAD, ST_RUN} ctlState_t;
  ctlState_t state;
  logic [QW-1:0] initCnt;
  logic s1Live, s1Enq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_LOAD;
      initCnt  <= '0;
      initBase <= '0;
      s1Live   <= 1'b0;
      s1Enq    <= 1'b0;
      s1Queue  <= '0;
    end else begin
      if (state == ST_LOAD) begin
        initCnt  <= initCnt + 1'b1;
        initBase <= initBase + BW'(DEPTH_FRAMES);   // step by one region
        if (initCnt == QW'(NUM_QUEUES - 1)) state <= ST_RUN;
      end
      s1Live  <= (state == ST_RUN) && reqValid;
      s1Enq   <= reqEnq;
      s1Queue <= reqQueue;
    end
  end

  assign ready          = (state == ST_RUN);
  assign strobes.initWr = (state == ST_LOAD);
  assign strobes.live   = s1Live;
  assign strobes.enq    = s1Enq;

  // R1: once raised, ready never drops
  a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);
  // R1: ready rises only after the last queue entry was loaded
  a_r1_ready_after_sweep: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> (initCnt == '0) && ($past(initCnt) == QW'(NUM_QUEUES - 1)));
endmodule

// File: rtl/qm_datapath.sv
module qm_datapath
  import qm_pkg::*;
#(
  parameter int NUM_QUEUES   = 64,
  parameter int DEPTH_FRAMES = 128,
  parameter int FRAME_BYTES  = 64
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  qmStrobe_t                            strobes,
  input  logic [$clog2(NUM_QUEUES)-1:0]        s1Queue,
  input  logic [$clog2(NUM_QUEUES)+$clog2(DEPTH_FRAMES)-1:0] initBase,
  input  logic [$clog2(DEPTH_FRAMES):0]        aeLevel,
  input  logic [$clog2(DEPTH_FRAMES):0]        afLevel,
  output logic                                 memValid,
  output logic                                 memWrite,
  output logic [$clog2(NUM_QUEUES)+$clog2(DEPTH_FRAMES)+$clog2(FRAME_BYTES)-1:0] memAddr,
  output logic                                 drop,
  output logic                                 statValid,
  output logic [$clog2(NUM_QUEUES)-1:0]        statQueue,
  output qmFlags_t                             statFlags
);
  localparam int QW = $clog2(NUM_QUEUES);
  localparam int DW = $clog2(DEPTH_FRAMES);
  localparam int OW = $clog2(FRAME_BYTES);
  localparam int BW = QW + DW;
  localparam int PW = 1 + BW;        // wrap bit, queue field, frame index
  localparam int AW = BW + OW;

  // pointer: {wrap, queue field, frame index}
  function automatic logic [PW-1:0] ptrStep(input logic [PW-1:0] p);
    logic [DW:0] w;
    w = {p[PW-1], p[DW-1:0]} + 1'b1;
    return {w[DW], p[BW-1:DW], w[DW-1:0]};
  endfunction

  function automatic logic [DW:0] occOf(input logic [PW-1:0] t, input logic [PW-1:0] h);
    return {t[PW-1], t[DW-1:0]} - {h[PW-1], h[DW-1:0]};
  endfunction

  function automatic qmFlags_t flagsOf(input logic [DW:0] occ,
                                       input logic [DW:0] ae, input logic [DW:0] af);
    qmFlags_t f;
    f.empty       = (occ == '0);
    f.full        = (occ == (DW+1)'(DEPTH_FRAMES));
    f.almostEmpty = (occ <= ae);
    f.almostFull  = (occ >= af);
    return f;
  endfunction

  // entry table
  logic [PW-1:0] headMem [NUM_QUEUES];
  logic [PW-1:0] tailMem [NUM_QUEUES];
  qmFlags_t      flagMem [NUM_QUEUES];

  // write-back stage
  logic          s2Valid;
  logic [QW-1:0] s2Queue;
  logic [PW-1:0] s2Head, s2Tail;
  qmFlags_t      s2Flags;

  // fetch stage: forward the entry still in write-back
  logic          fwd;
  logic [PW-1:0] curHead, curTail, nextHead, nextTail, accessPtr;
  qmFlags_t      curFlags, nextFlags;
  logic          doWrite, doRead, doDrop;

  always_comb begin
    fwd      = s2Valid && (s2Queue == s1Queue);
    curHead  = fwd ? s2Head  : headMem[s1Queue];
    curTail  = fwd ? s2Tail  : tailMem[s1Queue];
    curFlags = fwd ? s2Flags : flagMem[s1Queue];

    doWrite  = strobes.live &&  strobes.enq && !curFlags.full;
    doRead   = strobes.live && !strobes.enq && !curFlags.empty;
    doDrop   = strobes.live &&  strobes.enq &&  curFlags.full;

    nextHead  = doRead  ? ptrStep(curHead) : curHead;
    nextTail  = doWrite ? ptrStep(curTail) : curTail;
    nextFlags = flagsOf(occOf(nextTail, nextHead), aeLevel, afLevel);
    accessPtr = strobes.enq ? curTail : curHead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Valid  <= 1'b0;
      s2Queue  <= '0;
      s2Head   <= '0;
      s2Tail   <= '0;
      s2Flags  <= '0;
      memValid <= 1'b0;
      memWrite <= 1'b0;
      memAddr  <= '0;
      drop     <= 1'b0;
    end else begin
      s2Valid  <= strobes.live;
      s2Queue  <= s1Queue;
      s2Head   <= nextHead;
      s2Tail   <= nextTail;
      s2Flags  <= nextFlags;
      memValid <= doWrite || doRead;
      memWrite <= doWrite;
      memAddr  <= {accessPtr[BW-1:0], {OW{1'b0}}};
      drop     <= doDrop;
    end
  end

  // table writes: base load during start-up, write-back afterwards
  always_ff @(posedge clk) begin
    if (strobes.initWr) begin
      headMem[initBase[BW-1:DW]] <= {1'b0, initBase};
      tailMem[initBase[BW-1:DW]] <= {1'b0, initBase};
      flagMem[initBase[BW-1:DW]] <= flagsOf('0, aeLevel, afLevel);
    end else if (s2Valid) begin
      headMem[s2Queue] <= s2Head;
      tailMem[s2Queue] <= s2Tail;
      flagMem[s2Queue] <= s2Flags;
    end
  end

  assign statValid = s2Valid;
  assign statQueue = s2Queue;
  assign statFlags = s2Flags;

  // R5: occupancy held in an entry never exceeds the depth
  a_r5_occ_bounded: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> occOf(s2Tail, s2Head) <= (DW+1)'(DEPTH_FRAMES));
  // R5: a queue is never both full and empty
  a_r5_full_excl_empty: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> !(statFlags.full && statFlags.empty));
  // R4: a frame address always lies in the region of its own queue
  a_r4_addr_in_region: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memAddr[AW-1 -: QW] == statQueue) && (memAddr[OW-1:0] == '0));
  // R8: a refused enqueue makes no memory access
  a_r8_drop_no_access: assert property (@(posedge clk) disable iff (!rstN)
    drop |-> !memValid && statValid);
  // R7: a dequeue from an empty queue produces neither access nor drop
  a_r7_empty_dequeue_idle: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.live && !strobes.enq && curFlags.empty) |=> !memValid && !drop);
endmodule

// File: rtl/static_queue_ptr_mgr.sv
module static_queue_ptr_mgr
  import qm_pkg::*;
#(
  parameter int NUM_QUEUES   = 64,
  parameter int DEPTH_FRAMES = 128,
  parameter int FRAME_BYTES  = 64
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 reqValid,
  input  logic                                 reqEnq,
  input  logic [$clog2(NUM_QUEUES)-1:0]        reqQueue,
  input  logic [$clog2(DEPTH_FRAMES):0]        aeLevel,
  input  logic [$clog2(DEPTH_FRAMES):0]        afLevel,
  output logic                                 ready,
  output logic                                 memValid,
  output logic                                 memWrite,
  output logic [$clog2(NUM_QUEUES)+$clog2(DEPTH_FRAMES)+$clog2(FRAME_BYTES)-1:0] memAddr,
  output logic                                 drop,
  output logic                                 statValid,
  output logic [$clog2(NUM_QUEUES)-1:0]        statQueue,
  output logic                                 statEmpty,
  output logic                                 statFull,
  output logic                                 statAlmostEmpty,
  output logic                                 statAlmostFull
);
  localparam int QW = $clog2(NUM_QUEUES);
  localparam int BW = QW + $clog2(DEPTH_FRAMES);

  qmStrobe_t     strobes;
  logic [QW-1:0] s1Queue;
  logic [BW-1:0] initBase;
  qmFlags_t      statFlags;

  qm_ctrl #(.NUM_QUEUES(NUM_QUEUES), .DEPTH_FRAMES(DEPTH_FRAMES)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEnq(reqEnq),
    .reqQueue(reqQueue), .ready(ready), .strobes(strobes),
    .s1Queue(s1Queue), .initBase(initBase));

  qm_datapath #(.NUM_QUEUES(NUM_QUEUES), .DEPTH_FRAMES(DEPTH_FRAMES),
                .FRAME_BYTES(FRAME_BYTES)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .s1Queue(s1Queue),
    .initBase(initBase), .aeLevel(aeLevel), .afLevel(afLevel),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .drop(drop), .statValid(statValid), .statQueue(statQueue),
    .statFlags(statFlags));

  assign statEmpty       = statFlags.empty;
  assign statFull        = statFlags.full;
  assign statAlmostEmpty = statFlags.almostEmpty;
  assign statAlmostFull  = statFlags.almostFull;

  // R1: nothing leaves the block before the table is loaded
  a_r1_quiet_until_ready: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> !memValid && !statValid && !drop);
endmodule

// File: tb/test_static_queue_ptr_mgr.sv
`timescale 1ns/1ps
module test_static_queue_ptr_mgr;
  localparam int NQ = 64, DEPTH = 128, FB = 64;
  localparam int QW = 6, DW = 7, AW = 19;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqEnq = 1'b0;
  logic [QW-1:0] reqQueue = '0;
  logic [DW:0] aeLevel = 8'd2, afLevel = 8'd120;
  logic ready, memValid, memWrite, drop, statValid;
  logic [AW-1:0] memAddr;
  logic [QW-1:0] statQueue;
  logic statEmpty, statFull, statAlmostEmpty, statAlmostFull;

  always #2 clk = ~clk;   // 250 MHz

  static_queue_ptr_mgr #(.NUM_QUEUES(NQ), .DEPTH_FRAMES(DEPTH), .FRAME_BYTES(FB)) i_static_queue_ptr_mgr (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEnq(reqEnq), .reqQueue(reqQueue),
    .aeLevel(aeLevel), .afLevel(afLevel), .ready(ready), .memValid(memValid),
    .memWrite(memWrite), .memAddr(memAddr), .drop(drop), .statValid(statValid),
    .statQueue(statQueue), .statEmpty(statEmpty), .statFull(statFull),
    .statAlmostEmpty(statAlmostEmpty), .statAlmostFull(statAlmostFull));

  int checks = 0, fails = 0;
  int headM[NQ], tailM[NQ];
  int lastQ = -1;

  typedef struct {
    bit v, mv, mw, dr;
    int a, q;
    bit fe, ff, fae, faf;
    string tag;
  } exp_t;
  exp_t pipe0, pipe1;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(bit v, bit enq, int q);
    exp_t e;
    int occ, p;
    e.v = v; e.mv = 0; e.mw = 0; e.dr = 0; e.a = 0; e.q = q; e.tag = "R2";
    e.fe = 0; e.ff = 0; e.fae = 0; e.faf = 0;
    if (!v) begin lastQ = -1; return e; end
    occ = (tailM[q] - headM[q]) & 255;
    e.tag = enq ? "R2" : "R3";
    if (q == lastQ) e.tag = "R9";
    if (enq && occ == DEPTH) begin e.dr = 1; e.tag = "R8"; end
    else if (!enq && occ == 0) e.tag = "R7";
    else begin
      p = enq ? tailM[q] : headM[q];
      if ((p & (DEPTH-1)) == 0 && p != 0) e.tag = "R4";
      e.mv = 1; e.mw = enq;
      e.a = (q << 13) | ((p & (DEPTH-1)) << 6);
      if (enq) tailM[q] = (tailM[q] + 1) & 255;
      else     headM[q] = (headM[q] + 1) & 255;
    end
    occ = (tailM[q] - headM[q]) & 255;
    e.fe = (occ == 0); e.ff = (occ == DEPTH);
    e.fae = (occ <= int'(aeLevel)); e.faf = (occ >= int'(afLevel));
    lastQ = q;
    return e;
  endfunction

  task automatic step(bit v, bit enq, int q);
    @(negedge clk);
    chk(pipe1.tag, "memValid", memValid, pipe1.mv);
    chk("R8", "drop", drop, pipe1.dr);
    chk("R5", "statValid", statValid, pipe1.v);
    if (pipe1.v) begin
      chk("R5", "statQueue", statQueue, pipe1.q);
      chk("R5", "statEmpty", statEmpty, pipe1.fe);
      chk("R5", "statFull", statFull, pipe1.ff);
      chk("R6", "statAlmostEmpty", statAlmostEmpty, pipe1.fae);
      chk("R6", "statAlmostFull", statAlmostFull, pipe1.faf);
    end
    if (pipe1.mv) begin
      chk(pipe1.tag, "memWrite", memWrite, pipe1.mw);
      chk(pipe1.tag, "memAddr", memAddr, pipe1.a);
    end
    pipe1 = pipe0;
    reqValid = v; reqEnq = enq; reqQueue = QW'(q);
    pipe0 = model(v, enq, q);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NQ; i++) begin headM[i] = 0; tailM[i] = 0; end
    pipe0 = model(0, 0, 0); pipe1 = pipe0;
    // request held during reset and load: must be ignored (R1)
    reqValid = 1'b1; reqEnq = 1'b1; reqQueue = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int k = 1; k <= NQ; k++) begin
      @(negedge clk);
      if (k == 1)  chk("R1", "ready early", ready, 0);
      if (k == NQ-1) chk("R1", "ready before sweep end", ready, 0);
      if (k == NQ) chk("R1", "ready after sweep", ready, 1);
      chk("R1", "memValid during load", memValid, 0);
      chk("R1", "statValid during load", statValid, 0);
    end
    reqValid = 1'b0;
    // first enqueue to queue 0 starts at index 0: load-time request left no trace (R1)
    step(1, 1, 0);
    step(1, 0, 0);
    // fill queue 5 back to back (R2, R9), overflow (R8)
    for (int i = 0; i < DEPTH; i++) step(1, 1, 5);
    step(1, 1, 5);
    step(1, 1, 5);
    step(0, 0, 0);
    // drain past empty (R3, R7)
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 5);
    // wrap of index within region (R4)
    for (int i = 0; i < 3; i++) step(1, 1, 5);
    for (int i = 0; i < 3; i++) step(1, 0, 5);
    // thresholds (R6): change only while idle
    repeat (3) step(0, 0, 0);
    aeLevel = 8'd5; afLevel = 8'd3;
    repeat (2) step(0, 0, 0);
    for (int i = 0; i < 7; i++) step(1, 1, 9);
    for (int i = 0; i < 8; i++) step(1, 0, 9);
    repeat (3) step(0, 0, 0);
    aeLevel = 8'd10; afLevel = 8'd100;
    repeat (2) step(0, 0, 0);
    // constrained random, biased blocks to reach full and empty
    for (int blk = 0; blk < 10; blk++) begin
      int enqPct = (blk % 2 == 0) ? 80 : 20;
      for (int i = 0; i < 500; i++) begin
        int q = ($urandom % 8 == 0) ? int'($urandom % NQ) : int'($urandom % 3);
        bit v = ($urandom % 10) != 0;
        step(v, (int'($urandom % 100) < enqPct), q);
      end
    end
    repeat (3) step(0, 0, 0);
    summary();
  end
endmodule